// File: doc/BRIEF.md
# Inclusion Coherence Sweeper

This block applies coherence messages that arrive from a lower-level cache with large lines to a first-level data cache with smaller lines. One message names one lower-level line. That line covers several first-level lines. The block aligns the message address to the lower-level line. It then visits each first-level line inside that span, one per cycle, in order of increasing address.

For each visited line it looks up the first-level tag store. A line that hits is invalidated or downgraded to shared-clean, according to the message kind. For an invalidate, the block also tells the speculative-load tracker which line was lost. If the invalidate was sent on behalf of this cache's own requester id, the block also wipes the line's tag. A running count of dirty lines that were invalidated goes out with the single response that closes the message.

Messages enter on a valid/ready input. `msg_ready` is high only while the block is idle, so a second message waits until the previous response has been taken. The response is valid/ready as well. `rsp_valid` and `rsp_wb_count` stay steady while `rsp_ready` is low. The tag lookup, the tag update and the tracker notify are plain, same-cycle pins. The lookup is combinational: `lk_hit` and `lk_state` must answer `lk_addr` in the same cycle. The lower-level line must be larger than the first-level line.

Top module: `incl_coh_sweeper`

## Requirements
- R1: An accepted message address is aligned down to the lower-level line size (default 128 bytes). On the N consecutive cycles that follow acceptance, `lk_valid` is high and `lk_addr` gives the first-level lines of the span (default 32 bytes, so N = 4) in increasing order.
- R2: For an invalidate message (`msg_inval` = 1), every visited line that hits is written with state 0 (invalid). This happens through `upd_valid` with `upd_state` = 0 in that line's lookup cycle.
- R3: `rsp_wb_count` equals the number of hitting lines whose state was 3 (private-dirty) when an invalidate message visited them. This includes the last line of the span. The count is zero for a downgrade.
- R4: For a message with `msg_inval` = 0, every visited line that hits is written with state 1 (shared-clean). No tag is cleared and nothing is counted.
- R5: `upd_clear_tag` is high on a hitting line's update only when the message is an invalidate and `msg_src` equals `self_id`.
- R6: `spec_valid` pulses with `spec_addr` equal to the line address for each line that an invalidate turns invalid. It never pulses during a downgrade or on a miss.
- R7: A line for which `lk_hit` is 0 gets no update (`upd_valid` low) and adds nothing to the count, whatever `lk_state` shows.
- R8: Exactly one response is raised, on the cycle after the last line is visited. It holds its count while `rsp_ready` is low. `msg_ready` is low from acceptance until the response is taken, and high on the following cycle.
- R9: While and after reset, before any message arrives, `msg_ready` is 1 and `rsp_valid`, `lk_valid`, `upd_valid` and `spec_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_id | input | ID_W | Requester id of this cache |
| msg_valid | input | 1 | Coherence message offered |
| msg_ready | output | 1 | Block idle, message taken this cycle |
| msg_addr | input | ADDR_W | Byte address of the message |
| msg_inval | input | 1 | 1 = invalidate, 0 = downgrade to shared |
| msg_src | input | ID_W | Requester id that caused the message |
| lk_valid | output | 1 | Lookup active this cycle |
| lk_addr | output | ADDR_W | First-level line address being visited |
| lk_hit | input | 1 | Tag store hit for `lk_addr` |
| lk_state | input | 2 | Current state: 0 invalid, 1 shared, 2 private-clean, 3 private-dirty |
| upd_valid | output | 1 | Write `upd_state` to the line at `lk_addr` |
| upd_state | output | 2 | New line state |
| upd_clear_tag | output | 1 | Also wipe the line tag |
| spec_valid | output | 1 | Speculative-load tracker notify |
| spec_addr | output | ADDR_W | Line address that was invalidated |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_wb_count | output | CNT_W | Number of dirty lines invalidated |

## Verification
The dirty-line count can grow in the same cycle that the sweep finishes. The invalidation of the final sub-line and the step into the response phase share one clock edge, so a count register that updates late would leave that last line out. The bench sets up a span whose only dirty line is the highest one. It also runs a span where every line is dirty. In both cases it compares the reported count with the number of dirty hits it placed. A second pairing is response back-pressure coinciding with a waiting message. The bench keeps `msg_valid` high while `rsp_ready` is low and checks that no new lookup starts and that the count stays steady.

// File: rtl/incl_coh_pkg.sv
package incl_coh_pkg;
  typedef enum logic [1:0] {
    LS_INVALID = 2'd0,
    LS_SHARED  = 2'd1,
    LS_EXCL    = 2'd2,
    LS_DIRTY   = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SWEEP = 2'd1,
    PH_RESP  = 2'd2
  } phase_t;
endpackage

// File: rtl/incl_sweep_ctr.sv
module incl_sweep_ctr #(
  parameter int ADDR_W = 32,
  parameter int L1_OFF = 5,
  parameter int L2_OFF = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);
  localparam int IDX_W = L2_OFF - L1_OFF;
  localparam int HI_W  = ADDR_W - L2_OFF;
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [HI_W-1:0]  base_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (start) begin
      base_q <= start_addr[ADDR_W-1:L2_OFF];
      idx_q  <= '0;
    end else if (step) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_addr = {base_q, idx_q, {L1_OFF{1'b0}}};
  assign last     = (idx_q == IDX_MAX);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && $past(step) && !$past(start) && idx_q != '0) |->
      cur_addr == $past(cur_addr) + (ADDR_W'(1) << L1_OFF)); // R1
endmodule

// File: rtl/incl_line_action.sv
module incl_line_action
  import incl_coh_pkg::*;
(
  input  logic       active,
  input  logic       hit,
  input  logic [1:0] cur_state,
  input  logic       inval,
  input  logic       own_src,
  output logic       upd_valid,
  output logic [1:0] upd_state,
  output logic       clear_tag,
  output logic       notify,
  output logic       dirty_inc
);
  logic act_hit;

  always_comb begin
    act_hit   = active && hit;
    upd_valid = act_hit;
    upd_state = inval ? LS_INVALID : LS_SHARED;
    clear_tag = act_hit && inval && own_src;
    notify    = act_hit && inval;
    dirty_inc = act_hit && inval && (cur_state == LS_DIRTY);
  end
endmodule

// File: rtl/incl_wb_acc.sv
module incl_wb_acc #(
  parameter int MAX_CNT = 4,
  parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_CNT)); // R3
endmodule

// File: rtl/incl_coh_sweeper.sv
module incl_coh_sweeper
  import incl_coh_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 4,
  parameter int L1_BYTES = 32,
  parameter int L2_BYTES = 128,
  parameter int CNT_W    = $clog2(L2_BYTES / L1_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   self_id,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic              msg_inval,
  input  logic [ID_W-1:0]   msg_src,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic [1:0]        lk_state,
  output logic              upd_valid,
  output logic [1:0]        upd_state,
  output logic              upd_clear_tag,
  output logic              spec_valid,
  output logic [ADDR_W-1:0] spec_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CNT_W-1:0]  rsp_wb_count
);
  localparam int L1_OFF  = $clog2(L1_BYTES);
  localparam int L2_OFF  = $clog2(L2_BYTES);
  localparam int N_SUB   = L2_BYTES / L1_BYTES;

  phase_t phase_q;
  logic   inval_q, own_q;
  logic   accept, sweeping, last_sub, dirty_inc;

  assign accept   = msg_valid && (phase_q == PH_IDLE);
  assign sweeping = (phase_q == PH_SWEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      inval_q <= 1'b0;
      own_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (msg_valid) begin
          phase_q <= PH_SWEEP;
          inval_q <= msg_inval;
          own_q   <= (msg_src == self_id);
        end
        PH_SWEEP: if (last_sub) phase_q <= PH_RESP;
        PH_RESP:  if (rsp_ready) phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  incl_sweep_ctr #(.ADDR_W(ADDR_W), .L1_OFF(L1_OFF), .L2_OFF(L2_OFF)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_addr(msg_addr),
    .step(sweeping), .cur_addr(lk_addr), .last(last_sub)
  );

  incl_line_action u_act (
    .active(sweeping), .hit(lk_hit), .cur_state(lk_state),
    .inval(inval_q), .own_src(own_q),
    .upd_valid(upd_valid), .upd_state(upd_state), .clear_tag(upd_clear_tag),
    .notify(spec_valid), .dirty_inc(dirty_inc)
  );

  incl_wb_acc #(.MAX_CNT(N_SUB), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(dirty_inc), .count(rsp_wb_count)
  );

  assign msg_ready = (phase_q == PH_IDLE);
  assign lk_valid  = sweeping;
  assign spec_addr = lk_addr;
  assign rsp_valid = (phase_q == PH_RESP);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_wb_count))); // R8
  AST_IDLE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (msg_ready && !lk_valid)); // R8
  AST_SPEC_ONLY_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    spec_valid |-> (lk_hit && upd_state == LS_INVALID)); // R6
  AST_MISS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!upd_valid && !spec_valid && !upd_clear_tag)); // R7
  AST_CLEAR_ON_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    upd_clear_tag |-> (upd_valid && upd_state == LS_INVALID)); // R5
endmodule

// File: tb/incl_coh_sweeper_test.sv
`timescale 1ns/1ps
module incl_coh_sweeper_test;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] self_id = 4'd5;
  logic msg_valid = 1'b0, msg_inval = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] msg_addr = '0;
  logic [IW-1:0] msg_src = '0;
  logic msg_ready, lk_valid, lk_hit, upd_valid, upd_clear_tag, spec_valid, rsp_valid;
  logic [AW-1:0] lk_addr, spec_addr;
  logic [1:0] lk_state, upd_state;
  logic [CW-1:0] rsp_wb_count;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  incl_coh_sweeper uut (
    .clk(clk), .rst_n(rst_n), .self_id(self_id),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_inval(msg_inval), .msg_src(msg_src),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_state(lk_state),
    .upd_valid(upd_valid), .upd_state(upd_state), .upd_clear_tag(upd_clear_tag),
    .spec_valid(spec_valid), .spec_addr(spec_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_wb_count(rsp_wb_count)
  );

  // External tag store model: 16 first-level lines at byte 0..511
  logic [1:0] mst [16];
  logic       mtag[16];
  logic [AW-1:0] vis [8];
  logic [AW-1:0] spl [8];
  int nvis = 0, nspec = 0, nupd = 0;

  assign lk_hit   = mtag[lk_addr[8:5]];
  assign lk_state = mst[lk_addr[8:5]];

  always @(posedge clk) begin
    if (lk_valid) begin
      if (nvis < 8) vis[nvis] <= lk_addr;
      nvis <= nvis + 1;
    end
    if (spec_valid) begin
      if (nspec < 8) spl[nspec] <= spec_addr;
      nspec <= nspec + 1;
    end
    if (upd_valid) begin
      nupd <= nupd + 1;
      mst[lk_addr[8:5]] <= upd_state;
      if (upd_clear_tag) mtag[lk_addr[8:5]] <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input int l2, input logic [1:0] s0, input logic [1:0] s1,
                      input logic [1:0] s2, input logic [1:0] s3,
                      input logic [3:0] tags);
    @(negedge clk);
    mst[l2*4+0] = s0; mst[l2*4+1] = s1; mst[l2*4+2] = s2; mst[l2*4+3] = s3;
    for (int i = 0; i < 4; i++) mtag[l2*4+i] = tags[i];
  endtask

  // Send one message, hold response for 'hold' cycles, return count
  task automatic send(input logic [AW-1:0] a, input logic inv, input logic [IW-1:0] src,
                      input int hold, output logic [CW-1:0] cnt);
    @(negedge clk);
    nvis = 0; nspec = 0; nupd = 0;
    msg_addr = a; msg_inval = inv; msg_src = src; msg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R8 no response before last sub-line", {63'd0, rsp_valid}, 64'd0);
    @(negedge clk);
    chk("R8 response after last sub-line", {63'd0, rsp_valid}, 64'd1);
    cnt = rsp_wb_count;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R8 response held", {60'd0, rsp_valid, rsp_wb_count}, {60'd0, 1'b1, cnt});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 ready again", {63'd0, msg_ready}, 64'd1);
    chk("R8 single response", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R9 msg_ready", {63'd0, msg_ready}, 64'd1);
    chk("R9 outputs idle", {60'd0, rsp_valid, lk_valid, upd_valid, spec_valid}, 64'd0);
  endtask

  task automatic t_order_unaligned();
    logic [CW-1:0] c;
    fill(1, 2'd3, 2'd1, 2'd3, 2'd2, 4'b1111);
    send(32'h0000_00D3, 1'b1, 4'd2, 0, c);  // inside span 0x80..0xFF
    chk("R1 visit count", 64'(nvis), 64'd4);
    for (int i = 0; i < 4; i++) chk("R1 ascending aligned", 64'(vis[i]), 64'(32'h80 + i*32));
    for (int i = 0; i < 4; i++) chk("R2 invalidated", 64'(mst[4+i]), 64'd0);
    chk("R3 dirty count", 64'(c), 64'd2);
    chk("R6 notify count", 64'(nspec), 64'd4);
    for (int i = 0; i < 4; i++) chk("R6 notify addr", 64'(spl[i]), 64'(32'h80 + i*32));
    chk("R5 foreign id keeps tag", {60'd0, mtag[4], mtag[5], mtag[6], mtag[7]}, 64'hF);
  endtask

  task automatic t_downgrade();
    logic [CW-1:0] c;
    fill(2, 2'd3, 2'd2, 2'd1, 2'd3, 4'b1111);
    send(32'h0000_0100, 1'b0, 4'd5, 0, c);
    for (int i = 0; i < 4; i++) chk("R4 shared", 64'(mst[8+i]), 64'd1);
    chk("R4 no count", 64'(c), 64'd0);
    chk("R6 no notify on downgrade", 64'(nspec), 64'd0);
    chk("R4 tags kept", {60'd0, mtag[8], mtag[9], mtag[10], mtag[11]}, 64'hF);
  endtask

  task automatic t_miss();
    logic [CW-1:0] c;
    // lines 1 and 2 miss though state shows dirty
    fill(0, 2'd2, 2'd3, 2'd3, 2'd1, 4'b1001);
    send(32'h0000_0040, 1'b1, 4'd5, 0, c);
    chk("R7 miss state kept", {60'd0, mst[1], mst[2]}, {60'd0, 2'd3, 2'd3});
    chk("R7 hits invalidated", {60'd0, mst[0], mst[3]}, 64'd0);
    chk("R7 misses not counted", 64'(c), 64'd0);
    chk("R7 updates only on hits", 64'(nupd), 64'd2);
    chk("R6 notify only on hits", 64'(nspec), 64'd2);
    chk("R5 own id clears tag", {60'd0, mtag[0], mtag[3]}, 64'd0);
    chk("R7 miss tags untouched", {60'd0, mtag[1], mtag[2]}, 64'd0);
  endtask

  task automatic t_last_dirty_backpressure();
    logic [CW-1:0] c;
    fill(3, 2'd1, 2'd2, 2'd1, 2'd3, 4'b1111);
    send(32'h0000_01FF, 1'b1, 4'd1, 3, c);
    chk("R3 last sub-line counted", 64'(c), 64'd1);
    // message waiting while response blocked
    fill(3, 2'd3, 2'd3, 2'd3, 2'd3, 4'b1111);
    @(negedge clk);
    msg_addr = 32'h180; msg_inval = 1'b1; msg_src = 4'd1; msg_valid = 1'b1;
    nvis = 0;
    @(negedge clk);
    msg_valid = 1'b0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    msg_valid = 1'b1;  // offer next message while response waits
    msg_addr = 32'h0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no accept while busy", {62'd0, msg_ready, rsp_valid}, 64'd1);
    end
    chk("R3 all dirty counted", 64'(rsp_wb_count), 64'd4);
    chk("R8 no new lookup while waiting", 64'(nvis), 64'd4);
    msg_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 idle after response", {62'd0, msg_ready, lk_valid}, 64'd2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mst[i] = 2'd0; mtag[i] = 1'b0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_unaligned();
    t_downgrade();
    t_miss();
    t_last_dirty_backpressure();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule